// File: doc/BRIEF.md
# Reset Qualification and Strap Capture Sequencer

This block orders the bring-up of a hub-style controller after an external reset. The active-low reset pin is brought into the clock domain through two flops. It then has to stay low for a minimum number of cycles before it counts as a reset, so short glitches are rejected. A qualified reset sends the sequencer back to its reset phase from any phase. In the reset phase the block holds the downstream ports off, drops its outstanding requests and clears the captured strap word.

When the pin goes high again, the strap bus is captured once. After a fixed delay, the strap pins that are also outputs are turned around and driven to their inactive levels. The block then waits for the core to become operational. Next it requests a configuration load from external memory, unless a strap bit turns that load off, and then asserts upstream attach. Attach is held while the sequencer waits, for a bounded time, for a bus reset from the host. After that the sequencer rests in idle.

All delays are parameters counted in clock cycles. Their default values derive from `CLK_MHZ` and give about 1 µs minimum reset, 1.75 µs turnaround, 500 µs to operational, and 100 ms for both the attach deadline and the bus-reset wait.

Top module: `hub_rst_seq`

## Requirements
- R1: A low pulse on `ext_rst_n` that lasts fewer than `RST_MIN_CYC` clock cycles is ignored: `phase`, `attach` and `straps_q` keep their values. A pulse of exactly `RST_MIN_CYC` cycles counts as a reset.
- R2: A qualified reset, from any phase, puts `phase` at the reset code within `RST_MIN_CYC`+3 cycles. While in that phase, `dn_force_off` is 1, `cfg_req`, `attach` and `strap_oe` are 0, and `straps_q` is 0.
- R3: `straps_q` takes the value that `strap_in` has in the cycle where the synchronized pin is seen high after a qualified reset. Later changes of `strap_in` do not alter it.
- R4: The strap-latch phase lasts exactly one cycle and the output-drive phase lasts exactly `DRV_CYC` cycles, with `strap_oe` at 0 during both. From the wait-operational phase onward, `strap_oe` equals `OUT_MASK` and `strap_out` equals `IDLE_LVL & OUT_MASK`.
- R5: The wait-operational phase lasts exactly `OPER_CYC` cycles, and `cfg_req` is 0 during it.
- R6: When `straps_q[CFG_SKIP_BIT]` is 0, the config-load phase follows wait-operational and holds `cfg_req` at 1. If `cfg_done` is 1 in its n-th cycle, the attach phase starts on the next cycle.
- R7: When `straps_q[CFG_SKIP_BIT]` is 1, the config-load phase is skipped: wait-operational leads straight to attach, and `cfg_req` never rises.
- R8: If `cfg_done` does not arrive, the config-load phase ends so that attach begins exactly `ATT_CYC` cycles after the strap-latch cycle.
- R9: `attach` is 1 in the attach and idle phases. The attach phase moves to idle on the cycle after `host_bus_rst` is seen, or after `BRST_CYC` cycles without it. Idle is kept until a qualified reset.
- R10: `phase` uses these codes: 0 reset, 1 strap latch, 2 output drive, 3 wait operational, 4 config load, 5 attach, 6 idle.
- R11: Asserting `rst_n` low puts `phase` at 0 and holds `dn_force_off` at 1. A high `ext_rst_n` at release then starts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ext_rst_n | input | 1 | External active-low reset pin, asynchronous |
| strap_in | input | SW | Strap pin values |
| strap_oe | output | SW | Output enables for strap pins that double as outputs |
| strap_out | output | SW | Inactive levels driven on those pins |
| straps_q | output | SW | Captured strap word |
| dn_force_off | output | 1 | Forces downstream port enables and port power off |
| cfg_req | output | 1 | Configuration load request |
| cfg_done | input | 1 | Configuration load finished |
| host_bus_rst | input | 1 | Host-issued bus reset detected |
| attach | output | 1 | Upstream attach |
| phase | output | 3 | Current phase code |

## Verification
The bench sweeps reset pulse widths from one cycle up to one cycle past the minimum. This places the accept/reject boundary on an exact cycle. Every strap word of a 4-bit bus is applied with the input flipped right after capture, which separates a true capture from a transparent path and shows that bit 0 alone picks between the skip and load paths. Sweeps of the `cfg_done` delay and the bus-reset delay run across and past the deadline and timeout values, which shows whether each phase ends on the handshake or on its own counter. Qualified resets are also injected in each running phase to show that every phase returns to the reset state.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  typedef enum logic [2:0] {
    PH_RST    = 3'd0,
    PH_LATCH  = 3'd1,
    PH_DRIVE  = 3'd2,
    PH_WAITOP = 3'd3,
    PH_CFG    = 3'd4,
    PH_ATTACH = 3'd5,
    PH_IDLE   = 3'd6
  } phase_t;
endpackage

// File: rtl/hrs_sat_cnt.sv
module hrs_sat_cnt #(
  parameter int W   = 8,
  parameter int MAX = 100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TERM = W'(MAX);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (clr) q_nxt = '0;
    else if (en && (q != TERM)) q_nxt = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R8: the saturating count never passes its terminal value
  p_sat_limit_r8: assert property (@(posedge clk) disable iff (!rst_n) q <= TERM);
endmodule

// File: rtl/hrs_rst_qual.sv
module hrs_rst_qual #(
  parameter int MIN = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic hit,
  output logic rel
);
  localparam int CW = $clog2(MIN + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN - 1);
  localparam logic [CW-1:0] TOP  = CW'(MIN);

  logic s1, s2;
  logic [CW-1:0] cnt, cnt_nxt;
  logic armed, armed_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= pin_n;
      s2 <= s1;
    end
  end

  assign hit = !s2 && (cnt == LAST);
  assign rel = armed && s2;

  always_comb begin
    cnt_nxt = cnt;
    if (s2) cnt_nxt = '0;
    else if (cnt != TOP) cnt_nxt = cnt + 1'b1;
    armed_nxt = armed;
    if (hit) armed_nxt = 1'b1;
    else if (rel) armed_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else begin
      cnt   <= cnt_nxt;
      armed <= armed_nxt;
    end
  end

  generate
    if (MIN > 1) begin : g_chk
      // R1: a qualifying hit is never the first low cycle
      p_hit_needs_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !$past(s2));
    end
  endgenerate

  // R3: a release is followed by a disarmed qualifier
  p_rel_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rel |=> !rel);
endmodule

// File: rtl/hrs_strap.sv
module hrs_strap #(
  parameter int            SW       = 4,
  parameter logic [SW-1:0] OUT_MASK = '0,
  parameter logic [SW-1:0] IDLE_LVL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          clr,
  input  logic          drive_en,
  input  logic [SW-1:0] din,
  output logic [SW-1:0] q,
  output logic [SW-1:0] oe,
  output logic [SW-1:0] dout
);
  logic [SW-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (clr)      q_nxt = '0;
    else if (cap) q_nxt = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  for (genvar i = 0; i < SW; i++) begin : g_pin
    if (OUT_MASK[i]) begin : g_out
      assign oe[i]   = drive_en;
      assign dout[i] = IDLE_LVL[i];
    end else begin : g_in
      assign oe[i]   = 1'b0;
      assign dout[i] = 1'b0;
    end
  end

  // R3: the captured word moves only on a capture or a clear
  p_straps_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap && !clr) |=> $stable(q));
endmodule

// File: rtl/hub_rst_seq.sv
module hub_rst_seq
  import hrs_pkg::*;
#(
  parameter int            CLK_MHZ      = 50,
  parameter int            SW           = 4,
  parameter int            CFG_SKIP_BIT = 0,
  parameter logic [SW-1:0] OUT_MASK     = 'b0110,
  parameter logic [SW-1:0] IDLE_LVL     = 'b0100,
  parameter int            RST_MIN_CYC  = CLK_MHZ,
  parameter int            DRV_CYC      = CLK_MHZ * 7 / 4,
  parameter int            OPER_CYC     = CLK_MHZ * 500,
  parameter int            ATT_CYC      = CLK_MHZ * 100000,
  parameter int            BRST_CYC     = CLK_MHZ * 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_rst_n,
  input  logic [SW-1:0] strap_in,
  output logic [SW-1:0] strap_oe,
  output logic [SW-1:0] strap_out,
  output logic [SW-1:0] straps_q,
  output logic          dn_force_off,
  output logic          cfg_req,
  input  logic          cfg_done,
  input  logic          host_bus_rst,
  output logic          attach,
  output logic [2:0]    phase
);
  localparam int TMAX0 = (DRV_CYC > OPER_CYC) ? DRV_CYC : OPER_CYC;
  localparam int TMAX  = (TMAX0 > BRST_CYC) ? TMAX0 : BRST_CYC;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int GW    = $clog2(ATT_CYC + 1);
  localparam logic [TW-1:0] DRV_LAST  = TW'(DRV_CYC - 1);
  localparam logic [TW-1:0] OPER_LAST = TW'(OPER_CYC - 1);
  localparam logic [TW-1:0] BRST_LAST = TW'(BRST_CYC - 1);
  localparam logic [GW-1:0] ATT_LAST  = GW'(ATT_CYC - 1);

  phase_t ph, ph_nxt;
  logic hit, rel;
  logic [TW-1:0] tq;
  logic [GW-1:0] gq;
  logic drive_en, skip_cfg;

  hrs_rst_qual #(.MIN(RST_MIN_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .pin_n(ext_rst_n), .hit(hit), .rel(rel)
  );

  hrs_sat_cnt #(.W(TW), .MAX(TMAX)) u_ph_tmr (
    .clk(clk), .rst_n(rst_n), .clr((ph_nxt != ph) || hit), .en(1'b1), .q(tq)
  );

  hrs_sat_cnt #(.W(GW), .MAX(ATT_CYC - 1)) u_dl_tmr (
    .clk(clk), .rst_n(rst_n), .clr(ph == PH_RST), .en(1'b1), .q(gq)
  );

  assign drive_en = (ph == PH_WAITOP) || (ph == PH_CFG) ||
                    (ph == PH_ATTACH) || (ph == PH_IDLE);

  hrs_strap #(.SW(SW), .OUT_MASK(OUT_MASK), .IDLE_LVL(IDLE_LVL)) u_strap (
    .clk(clk), .rst_n(rst_n),
    .cap((ph == PH_RST) && rel && !hit), .clr(hit),
    .drive_en(drive_en), .din(strap_in),
    .q(straps_q), .oe(strap_oe), .dout(strap_out)
  );

  assign skip_cfg = straps_q[CFG_SKIP_BIT];

  always_comb begin
    ph_nxt = ph;
    unique case (ph)
      PH_RST:    if (rel) ph_nxt = PH_LATCH;
      PH_LATCH:  ph_nxt = PH_DRIVE;
      PH_DRIVE:  if (tq == DRV_LAST) ph_nxt = PH_WAITOP;
      PH_WAITOP: if (tq == OPER_LAST) ph_nxt = skip_cfg ? PH_ATTACH : PH_CFG;
      PH_CFG:    if (cfg_done || (gq == ATT_LAST)) ph_nxt = PH_ATTACH;
      PH_ATTACH: if (host_bus_rst || (tq == BRST_LAST)) ph_nxt = PH_IDLE;
      PH_IDLE:   ph_nxt = PH_IDLE;
      default:   ph_nxt = PH_RST;
    endcase
    if (hit) ph_nxt = PH_RST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_RST;
    else        ph <= ph_nxt;
  end

  assign dn_force_off = (ph == PH_RST);
  assign cfg_req      = (ph == PH_CFG);
  assign attach       = (ph == PH_ATTACH) || (ph == PH_IDLE);
  assign phase        = ph;

  // R2: a qualified hit always lands in the reset phase
  p_hit_to_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (ph == PH_RST));
  // R4: strap latch lasts one cycle
  p_latch_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_LATCH) |=> (ph == PH_DRIVE) || (ph == PH_RST));
  // R6: done ends the config phase on the next cycle
  p_cfg_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_CFG) && cfg_done && !hit) |=> (ph == PH_ATTACH));
  // R9: idle is kept until a qualified reset
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_IDLE) && !hit) |=> (ph == PH_IDLE));
endmodule

// File: tb/sim_hub_rst_seq.sv
module sim_hub_rst_seq;
  localparam int SW = 4;
  localparam int RMIN = 4, DRV = 6, OPER = 10, ATT = 40, BRST = 15;
  localparam logic [SW-1:0] MASK = 4'b0110, LVL = 4'b0100;

  logic clk = 1'b0, rst_n = 1'b0, ext_rst_n = 1'b1;
  logic [SW-1:0] strap_in = '0;
  logic cfg_done = 1'b0, host_bus_rst = 1'b0;
  logic [SW-1:0] strap_oe, strap_out, straps_q;
  logic dn_force_off, cfg_req, attach;
  logic [2:0] phase;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  hub_rst_seq #(.SW(SW), .OUT_MASK(MASK), .IDLE_LVL(LVL), .RST_MIN_CYC(RMIN),
    .DRV_CYC(DRV), .OPER_CYC(OPER), .ATT_CYC(ATT), .BRST_CYC(BRST)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .strap_in(strap_in),
    .strap_oe(strap_oe), .strap_out(strap_out), .straps_q(straps_q),
    .dn_force_off(dn_force_off), .cfg_req(cfg_req), .cfg_done(cfg_done),
    .host_bus_rst(host_bus_rst), .attach(attach), .phase(phase));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic span(input int p, output int n);
    n = 0;
    while (phase == p && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_phase(input int p);
    for (int i = 0; i < 300 && phase != p; i++) @(negedge clk);
  endtask

  task automatic check_rst_state(input string req);
    chk({req, " phase"}, phase, 0);
    chk({req, " force_off"}, dn_force_off, 1);
    chk({req, " cfg_req"}, cfg_req, 0);
    chk({req, " attach"}, attach, 0);
    chk({req, " oe"}, strap_oe, 0);
    chk({req, " straps"}, straps_q, 0);
  endtask

  task automatic pulse_rst(input int w);
    ext_rst_n = 1'b0;
    repeat (w) @(negedge clk);
    ext_rst_n = 1'b1;
  endtask

  // full sequence with a given strap word and handshake delays
  task automatic run_seq(input logic [SW-1:0] s, input int dd, input int db);
    int n, exp;
    strap_in = s;
    ext_rst_n = 1'b0;
    repeat (RMIN + 5) @(negedge clk);
    check_rst_state("R2");
    ext_rst_n = 1'b1;
    wait_phase(1);
    strap_in = ~s;
    chk("R3 captured straps", straps_q, s);
    chk("R10 latch code", phase, 1);
    span(1, n); chk("R4 latch length", n, 1);
    chk("R4 oe off in drive", strap_oe, 0);
    span(2, n); chk("R4 drive length", n, DRV);
    chk("R4 oe after drive", strap_oe, MASK);
    chk("R4 strap_out level", strap_out, LVL & MASK);
    chk("R5 no cfg_req in wait", cfg_req, 0);
    span(3, n); chk("R5 wait-op length", n, OPER);
    if (s[0]) begin
      chk("R7 skip to attach", phase, 5);
      chk("R7 no cfg_req", cfg_req, 0);
    end else begin
      chk("R6 config phase", phase, 4);
      chk("R6 cfg_req high", cfg_req, 1);
      n = 0;
      while (phase == 4 && n < 1000) begin
        cfg_done = (n == dd);
        @(negedge clk); n++;
      end
      cfg_done = 1'b0;
      exp = (dd + 1 < ATT - 1 - DRV - OPER) ? dd + 1 : ATT - 1 - DRV - OPER;
      chk((dd + 1 < exp + 1 && dd + 1 == exp) ? "R6 cfg length on done" :
          "R8 cfg length on deadline", n, exp);
    end
    chk("R9 attach in attach phase", attach, 1);
    n = 0;
    while (phase == 5 && n < 1000) begin
      host_bus_rst = (n == db);
      @(negedge clk); n++;
    end
    host_bus_rst = 1'b0;
    exp = (db + 1 < BRST) ? db + 1 : BRST;
    chk("R9 attach length", n, exp);
    chk("R9 idle code", phase, 6);
    chk("R9 attach in idle", attach, 1);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check_rst_state("R11");
    rst_n = 1'b1;
    wait_phase(6);
    chk("R11 start after system reset", phase, 6);

    // R3 / R7: every strap word
    for (int s = 0; s < 16; s++) run_seq(SW'(s), 3, 3);
    // R6 / R8: done delay across the deadline
    for (int d = 0; d < 26; d++) run_seq(4'b0000, d, 2);
    // R9: bus reset delay across the timeout
    for (int b = 0; b < 17; b++) run_seq(4'b0001, 0, b);

    // R1: glitch widths around the minimum, from idle
    for (int w = 1; w <= RMIN + 1; w++) begin
      run_seq(4'b1011, 0, 0);
      strap_in = 4'b0101;
      pulse_rst(w);
      repeat (5) @(negedge clk);
      if (w < RMIN) begin
        chk("R1 glitch ignored phase", phase, 6);
        chk("R1 glitch ignored attach", attach, 1);
        chk("R1 glitch ignored straps", straps_q, 4'b1011);
      end else begin
        chk("R1 valid pulse restarts", (phase >= 1 && phase <= 2) ? 1 : 0, 1);
        chk("R1 new straps taken", straps_q, 4'b0101);
        wait_phase(6);
      end
    end

    // R2: qualified reset injected in every running phase
    for (int p = 1; p <= 6; p++) begin
      strap_in = 4'b0010;
      pulse_rst(RMIN + 5);
      wait_phase(p);
      chk("R2 reached phase", phase, p);
      ext_rst_n = 1'b0;
      repeat (RMIN + 3) @(negedge clk);
      check_rst_state("R2");
      ext_rst_n = 1'b1;
      wait_phase(6);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule